// File: doc/BRIEF.md
# I2C Indirect Register Access Slave

This block is an I2C slave front end that gives a bus master access to a bank of 16-bit internal registers. Access is indirect. The master addresses the device and sends a one-byte mode selector, which picks either a register write or a register read. It then sends a 16-bit register pointer, high byte first.

In write mode, two data bytes follow, high byte first. The block then issues a single write request to the register bank. It does this only after the second data byte has been acknowledged.

In read mode, the master keeps the bus, issues a repeated START and addresses the device for reading. The block fetches the pointed register through the bank's request/grant port and returns it as two bytes, high byte first. The master ends the read with a NAK and a STOP.

SCL and SDA are open-drain: each output port is a pull-low enable. At the end of every acknowledged received byte, the block holds SCL low while the internal controller reports busy or a bank request is still waiting for its grant. This puts the master into a wait state. A timeout counter bounds the hold. If it expires, the block lets go of SCL, flags an error and abandons the transfer, so the bus can never lock up.

Top module: `i2c_ira_slave`

## Requirements
- R1: After reset, scl_oe, sda_oe, reg_req and stretch_err are all 0.
- R2: A device address byte whose upper seven bits equal DEV_ADDR (default 7'b1000101) is acknowledged. The lowest bit selects the direction: 0 for write, 1 for read. Any other address gets a NAK, and every later byte is ignored (NAK) until the next START.
- R3: After a write-direction device address, the selector byte 0x12 (write mode) or 0x13 (read mode) is acknowledged. Any other value gets a NAK, and the block returns to idle without touching the bank.
- R4: In write mode, the bytes after the selector are pointer high, pointer low, data high and data low, each acknowledged. Exactly one request is then raised with reg_we=1, reg_addr equal to the pointer and reg_wdata equal to the data. It is raised only after the low data byte's ACK, and it is held with a stable address until reg_gnt.
- R5: A read-direction device address that follows a pointer loaded in read mode raises a request with reg_we=0. reg_rdata is captured in the grant cycle, and the two bytes are returned high byte first, most significant bit first.
- R6: A read-direction device address gets a NAK unless a pointer was loaded in read mode since the last STOP.
- R7: After the master's NAK on the low data byte, and whenever the block is idle, SDA is released (sda_oe=0).
- R8: At the end of the ACK bit of each acknowledged received byte, SCL is held low while busy is 1 or a bank request is outstanding. It is released once both have cleared.
- R9: If the hold lasts TOUT_CYC clock cycles, SCL is released, stretch_err is set, any pending request is dropped and the transfer is abandoned (later bytes get a NAK). stretch_err clears at the next START.
- R10: START is an SDA fall while SCL is high; STOP is an SDA rise while SCL is high. A STOP returns the block to idle from any point, and an incomplete write raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK or data 0) |
| busy | input | 1 | Internal controller not ready |
| reg_req | output | 1 | Register bank request, held until grant |
| reg_we | output | 1 | Request is a write |
| reg_addr | output | 16 | Register pointer |
| reg_wdata | output | 16 | Write data |
| reg_gnt | input | 1 | Bank grant, one cycle |
| reg_rdata | input | 16 | Read data, valid with grant |
| stretch_err | output | 1 | Stretch timeout occurred in this transfer |

## Verification
The bench builds the block with TOUT_CYC set to 2000 instead of the default one million. This brings the stretch timeout, with its released clock, error flag and abandoned transfer, within a few thousand cycles. The address, selector codes and two-stage synchronizer keep their defaults, so the bench drives the real protocol codes. A bus period of 16 clocks leaves the three-cycle edge-detection latency well inside each SCL phase. Bank grant latency and busy pulses are varied, so the stretch is exercised both by the controller's busy signal and by a slow grant.

// File: rtl/i2c_ira_pkg.sv
// Package: shared types for the indirect register access slave.
// Assumes the register word is two bus bytes wide.
package i2c_ira_pkg;
    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RX, PH_RXACK, PH_LOAD, PH_TX, PH_TXACK
    } phase_t;

    typedef enum logic [2:0] {
        SG_DEV, SG_SUB, SG_AHI, SG_ALO, SG_DHI, SG_DLO, SG_DONE
    } stage_t;
endpackage

// File: rtl/i2c_ira_sync.sv
// Line synchronizer and bus condition detector.
// Brings SCL and SDA into the clock domain through SYNC_LEN flops and
// flags SCL edges, START and STOP. Assumes SCL is much slower than clk.
module i2c_ira_sync #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_LEN-1:0] scl_pipe, sda_pipe;
    logic scl_d, sda_d, scl_s;

    // Shift the raw lines through the synchronizer and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_LEN-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_LEN-2:0], sda_i};
            scl_d    <= scl_pipe[SYNC_LEN-1];
            sda_d    <= sda_pipe[SYNC_LEN-1];
        end
    end

    // Decode edges and bus conditions from the two newest samples.
    always_comb begin
        scl_s     = scl_pipe[SYNC_LEN-1];
        sda_s     = sda_pipe[SYNC_LEN-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

    AST_COND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det, scl_rise, scl_fall})); // R10
endmodule

// File: rtl/i2c_ira_stretch.sv
// Clock stretch controller.
// On an engage pulse at a byte boundary it holds SCL low until busy and
// the pending bank request are both clear, or until TOUT_CYC cycles pass,
// in which case it releases SCL and emits a one-cycle timeout pulse.
module i2c_ira_stretch #(
    parameter int TOUT_CYC = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic engage,
    input  logic busy,
    input  logic pend,
    output logic scl_hold,
    output logic tout
);
    localparam int CW = $clog2(TOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TOUT_CYC - 1);

    logic [CW-1:0] cnt;

    // Track the hold and its length; release on ready or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_hold <= 1'b0;
            tout     <= 1'b0;
            cnt      <= '0;
        end else begin
            tout <= 1'b0;
            if (engage) begin
                scl_hold <= 1'b1;
                cnt      <= '0;
            end else if (scl_hold) begin
                if (!busy && !pend) begin
                    scl_hold <= 1'b0;
                end else if (cnt == LAST) begin
                    scl_hold <= 1'b0;
                    tout     <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_TOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        tout |-> !scl_hold); // R9
    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> (cnt <= LAST)); // R9
endmodule

// File: rtl/i2c_ira_slave.sv
// Indirect register access I2C slave (top).
// Decodes device address, mode selector, 16-bit pointer and data bytes,
// issues one bank request per access and stretches SCL at byte boundaries.
// Assumes one master and 7-bit addressing; lines are open-drain enables.
module i2c_ira_slave
    import i2c_ira_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1000101,
    parameter logic [7:0] SUB_WR   = 8'h12,
    parameter logic [7:0] SUB_RD   = 8'h13,
    parameter int         TOUT_CYC = 1000000,
    parameter int         SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             busy,
    output logic             reg_req,
    output logic             reg_we,
    output logic [REG_W-1:0] reg_addr,
    output logic [REG_W-1:0] reg_wdata,
    input  logic             reg_gnt,
    input  logic [REG_W-1:0] reg_rdata,
    output logic             stretch_err
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic engage, tout, scl_hold, byte_ok;

    phase_t            phase;
    stage_t            stage;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg, tx_lo;
    logic              wr_sel, ptr_rd_ok, rd_xfer, tx_hi, mack;

    i2c_ira_sync #(.SYNC_LEN(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_ira_stretch #(.TOUT_CYC(TOUT_CYC)) u_stretch (
        .clk(clk), .rst_n(rst_n), .engage(engage), .busy(busy),
        .pend(reg_req), .scl_hold(scl_hold), .tout(tout)
    );

    assign scl_oe = scl_hold;

    // Decide whether the byte just received is acknowledged.
    always_comb begin
        case (stage)
            SG_DEV:         byte_ok = (shreg[7:1] == DEV_ADDR) && (!shreg[0] || ptr_rd_ok);
            SG_SUB:         byte_ok = (shreg == SUB_WR) || (shreg == SUB_RD);
            SG_AHI, SG_ALO: byte_ok = 1'b1;
            SG_DHI, SG_DLO: byte_ok = wr_sel;
            default:        byte_ok = 1'b0;
        endcase
    end

    // Request a stretch at the end of every ACK bit the slave drove.
    assign engage = (phase == PH_RXACK) && scl_fall && !start_det && !stop_det && !tout;

    // Protocol sequencer: bit shifting, ACK drive, pointer, data and requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            stage       <= SG_DEV;
            bitcnt      <= '0;
            shreg       <= '0;
            tx_lo       <= '0;
            wr_sel      <= 1'b0;
            ptr_rd_ok   <= 1'b0;
            rd_xfer     <= 1'b0;
            tx_hi       <= 1'b0;
            mack        <= 1'b0;
            sda_oe      <= 1'b0;
            reg_req     <= 1'b0;
            reg_we      <= 1'b0;
            reg_addr    <= '0;
            reg_wdata   <= '0;
            stretch_err <= 1'b0;
        end else begin
            if (reg_req && reg_gnt) reg_req <= 1'b0;
            if (tout) begin
                phase       <= PH_IDLE;
                sda_oe      <= 1'b0;
                reg_req     <= 1'b0;
                ptr_rd_ok   <= 1'b0;
                stretch_err <= 1'b1;
            end else if (start_det) begin
                phase       <= PH_RX;
                stage       <= SG_DEV;
                bitcnt      <= '0;
                sda_oe      <= 1'b0;
                stretch_err <= 1'b0;
            end else if (stop_det) begin
                phase     <= PH_IDLE;
                sda_oe    <= 1'b0;
                ptr_rd_ok <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end
                        if (scl_fall && bitcnt == 4'd8) begin
                            if (byte_ok) begin
                                sda_oe <= 1'b1;
                                phase  <= PH_RXACK;
                                case (stage)
                                    SG_DEV: rd_xfer <= shreg[0];
                                    SG_SUB: begin
                                        wr_sel    <= (shreg == SUB_WR);
                                        ptr_rd_ok <= 1'b0;
                                    end
                                    SG_AHI: reg_addr[15:8] <= shreg;
                                    SG_ALO: begin
                                        reg_addr[7:0] <= shreg;
                                        if (!wr_sel) ptr_rd_ok <= 1'b1;
                                    end
                                    SG_DHI: reg_wdata[15:8] <= shreg;
                                    SG_DLO: reg_wdata[7:0]  <= shreg;
                                    default: ;
                                endcase
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= PH_IDLE;
                            end
                        end
                    end
                    PH_RXACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            phase  <= PH_RX;
                            case (stage)
                                SG_DEV: begin
                                    if (rd_xfer) begin
                                        reg_req <= 1'b1;
                                        reg_we  <= 1'b0;
                                        phase   <= PH_LOAD;
                                    end else begin
                                        stage <= SG_SUB;
                                    end
                                end
                                SG_SUB: stage <= SG_AHI;
                                SG_AHI: stage <= SG_ALO;
                                SG_ALO: begin
                                    stage <= wr_sel ? SG_DHI : SG_DONE;
                                    if (!wr_sel) phase <= PH_IDLE;
                                end
                                SG_DHI: stage <= SG_DLO;
                                default: begin
                                    reg_req <= 1'b1;
                                    reg_we  <= 1'b1;
                                    stage   <= SG_DONE;
                                    phase   <= PH_IDLE;
                                end
                            endcase
                        end
                    end
                    PH_LOAD: begin
                        if (reg_req && reg_gnt) begin
                            shreg  <= reg_rdata[15:8];
                            tx_lo  <= reg_rdata[7:0];
                            tx_hi  <= 1'b1;
                            sda_oe <= ~reg_rdata[15];
                            bitcnt <= 4'd1;
                            phase  <= PH_TX;
                        end
                    end
                    PH_TX: begin
                        if (scl_fall) begin
                            if (bitcnt < 4'd8) begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                                bitcnt <= bitcnt + 4'd1;
                            end else begin
                                sda_oe <= 1'b0;
                                mack   <= 1'b0;
                                phase  <= PH_TXACK;
                            end
                        end
                    end
                    PH_TXACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall) begin
                            if (mack && tx_hi) begin
                                shreg  <= tx_lo;
                                sda_oe <= ~tx_lo[7];
                                tx_hi  <= 1'b0;
                                bitcnt <= 4'd1;
                                phase  <= PH_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_gnt && !tout) |=> reg_req); // R4
    AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_gnt && !tout) |=> $stable(reg_addr)); // R4
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !tout) |=> (phase == PH_IDLE)); // R10
    AST_IDLE_SDA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_oe); // R7
endmodule

// File: tb/tb_i2c_ira_slave.sv
module tb_i2c_ira_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;
    localparam int TOUT = 2000;
    localparam logic [7:0] DEVW = 8'h8A;
    localparam logic [7:0] DEVR = 8'h8B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b0, m_sda = 1'b0;
    logic busy = 1'b0;
    logic scl_oe, sda_oe, reg_req, reg_we, stretch_err;
    logic [15:0] reg_addr, reg_wdata, reg_rdata;
    logic reg_gnt;
    wire scl_ln = !(m_scl || scl_oe);
    wire sda_ln = !(m_sda || sda_oe);

    int n_chk = 0, n_bad = 0, max_str = 0, gnt_lat = 0, lat = 0, wr_cnt = 0;
    logic [15:0] bk [16];
    logic [15:0] exp_mem [16];
    logic [15:0] last_a, last_d;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ira_slave #(.TOUT_CYC(TOUT)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .reg_req(reg_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_gnt(reg_gnt), .reg_rdata(reg_rdata), .stretch_err(stretch_err)
    );

    // Register bank model with programmable grant latency.
    assign reg_rdata = bk[reg_addr[3:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            reg_gnt <= 1'b0;
            lat <= 0;
            for (int i = 0; i < 16; i++) bk[i] <= '0;
        end else if (reg_req && !reg_gnt) begin
            if (lat >= gnt_lat) begin
                reg_gnt <= 1'b1;
                lat <= 0;
                if (reg_we) begin
                    bk[reg_addr[3:0]] <= reg_wdata;
                    wr_cnt <= wr_cnt + 1;
                    last_a <= reg_addr;
                    last_d <= reg_wdata;
                end
            end else lat <= lat + 1;
        end else begin
            reg_gnt <= 1'b0;
            lat <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high();
        int c = 0;
        while (!scl_ln) begin
            @(negedge clk);
            c++;
        end
        if (c > max_str) max_str = c;
    endtask

    task automatic m_start();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wait_high(); wq(Q);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b0; wait_high(); wq(Q);
        m_sda = 1'b0; wq(Q);
    endtask

    task automatic m_bit(input bit b, output bit r);
        m_sda = !b; wq(Q);
        m_scl = 1'b0; wait_high(); wq(Q);
        r = sda_ln; wq(Q);
        m_scl = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) m_bit(b[i], r);
        m_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            d[i] = r;
        end
        m_bit(!give_ack, r);
    endtask

    function automatic int ack_sum(input bit a, b, c, d, e, f);
        return int'(a) + int'(b) + int'(c) + int'(d) + int'(e) + int'(f);
    endfunction

    task automatic do_write(input logic [15:0] a, input logic [15:0] d, output int acks);
        bit k0, k1, k2, k3, k4, k5;
        m_start();
        send_byte(DEVW, k0); send_byte(8'h12, k1);
        send_byte(a[15:8], k2); send_byte(a[7:0], k3);
        send_byte(d[15:8], k4); send_byte(d[7:0], k5);
        m_stop();
        acks = ack_sum(k0, k1, k2, k3, k4, k5);
        exp_mem[a[3:0]] = d;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [15:0] d, output int acks, output bit rel);
        bit k0, k1, k2, k3, k4;
        logic [7:0] hi, lo;
        m_start();
        send_byte(DEVW, k0); send_byte(8'h13, k1);
        send_byte(a[15:8], k2); send_byte(a[7:0], k3);
        m_start();
        send_byte(DEVR, k4);
        recv_byte(1'b1, hi);
        recv_byte(1'b0, lo);
        wq(2);
        rel = !sda_oe;
        m_stop();
        d = {hi, lo};
        acks = ack_sum(k0, k1, k2, k3, k4, 1'b1) - 1;
    endtask

    initial begin
        int acks, prev;
        bit ack, rel;
        logic [15:0] d;
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) exp_mem[i] = '0;
        wq(5);
        rst_n = 1'b1;
        wq(3);
        // R1 reset state
        chk(!scl_oe && !sda_oe && !reg_req && !stretch_err, "R1 reset outputs",
            {28'd0, scl_oe, sda_oe, reg_req, stretch_err}, 0);

        // R4 directed write with commit point
        prev = wr_cnt;
        begin
            bit k0, k1, k2, k3, k4, k5;
            m_start();
            send_byte(DEVW, k0); send_byte(8'h12, k1);
            send_byte(8'h00, k2); send_byte(8'h03, k3);
            send_byte(8'hA5, k4);
            chk(wr_cnt == prev, "R4 no commit before low data byte", wr_cnt, prev);
            send_byte(8'h5A, k5);
            m_stop();
            chk(k0 && k1, "R2 R3 address and selector ACK", {k0, k1}, 2'b11);
            chk(k2 && k3 && k4 && k5, "R4 pointer and data ACK", {k2, k3, k4, k5}, 4'hF);
            exp_mem[3] = 16'hA55A;
        end
        chk(wr_cnt == prev + 1, "R4 exactly one write", wr_cnt, prev + 1);
        chk(last_a == 16'h0003 && last_d == 16'hA55A, "R4 write addr/data",
            {last_a, last_d}, 32'h0003A55A);

        // R5/R7 directed read
        do_read(16'h0003, d, acks, rel);
        chk(d == 16'hA55A, "R5 read data order", d, 16'hA55A);
        chk(acks == 5, "R5 read ACKs", acks, 5);
        chk(rel, "R7 SDA released after master NAK", sda_oe, 0);

        // R2 wrong device address then ignored
        m_start();
        send_byte(8'h8C, ack);
        chk(!ack, "R2 foreign address NAK", ack, 0);
        send_byte(8'h12, ack);
        chk(!ack, "R2 bytes ignored after NAK", ack, 0);
        m_stop();

        // R3 bad selector
        prev = wr_cnt;
        m_start();
        send_byte(DEVW, ack);
        send_byte(8'h20, ack);
        chk(!ack, "R3 bad selector NAK", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R3 idle after bad selector", ack, 0);
        m_stop();
        wq(4);
        chk(wr_cnt == prev && !reg_req, "R3 no bank access", wr_cnt, prev);

        // R6 read without pointer, and pointer dropped by STOP
        m_start();
        send_byte(DEVR, ack);
        chk(!ack, "R6 read address NAK without pointer", ack, 0);
        m_stop();
        m_start();
        send_byte(DEVW, ack); send_byte(8'h13, ack);
        send_byte(8'h00, ack); send_byte(8'h03, ack);
        m_stop();
        m_start();
        send_byte(DEVR, ack);
        chk(!ack, "R6 R10 pointer cleared by STOP", ack, 0);
        m_stop();

        // R10 STOP in mid write
        prev = wr_cnt;
        m_start();
        send_byte(DEVW, ack); send_byte(8'h12, ack); send_byte(8'h00, ack);
        m_stop();
        wq(4);
        chk(wr_cnt == prev && !reg_req, "R10 aborted write raises no request", wr_cnt, prev);

        // R8 stretch from busy
        max_str = 0;
        fork
            begin busy = 1'b1; wq(600); busy = 1'b0; end
        join_none
        do_write(16'h1207, 16'h3C3C, acks);
        chk(max_str >= 300, "R8 SCL held while busy", max_str, 300);
        chk(acks == 6 && bk[7] == 16'h3C3C, "R8 write completes after busy", {acks, bk[7]}, {32'd6, 16'h3C3C});

        // R8 stretch from slow grant
        max_str = 0;
        gnt_lat = 40;
        do_read(16'h0007, d, acks, rel);
        chk(max_str >= 35, "R8 SCL held until grant", max_str, 35);
        chk(d == 16'h3C3C, "R5 read after slow grant", d, 16'h3C3C);
        gnt_lat = 0;

        // R9 timeout
        max_str = 0;
        busy = 1'b1;
        m_start();
        send_byte(DEVW, ack);
        send_byte(8'h12, ack);
        chk(!ack, "R9 transfer abandoned after timeout", ack, 0);
        chk(stretch_err, "R9 error flag set", stretch_err, 1);
        chk(max_str >= TOUT - 10 && max_str <= TOUT + 20, "R9 hold bounded by timeout", max_str, TOUT);
        busy = 1'b0;
        m_stop();
        m_start();
        chk(!stretch_err, "R9 error cleared at START", stretch_err, 0);
        m_stop();

        // Random write / read-back
        for (int it = 0; it < 25; it++) begin
            logic [15:0] ra, rd;
            ra = 16'($urandom);
            rd = 16'($urandom);
            gnt_lat = int'($urandom % 6);
            if ($urandom % 4 == 0) begin
                fork
                    begin busy = 1'b1; wq(50); busy = 1'b0; end
                join_none
            end
            do_write(ra, rd, acks);
            chk(acks == 6 && last_a == ra && last_d == rd, "R4 random write",
                {last_a, last_d}, {ra, rd});
            ra = {16'($urandom)} & 16'hFFF0 | 16'(it % 16);
            do_read(ra, d, acks, rel);
            chk(d == exp_mem[ra[3:0]] && acks == 5, "R5 random read", d, exp_mem[ra[3:0]]);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule